// File: doc/BRIEF.md
# Crate Dataway Command and Attention Responder

This block is the slave-side command decoder for a twelve-channel digitizer card on a CAMAC crate backplane. Each command is modelled as one strobe cycle. In that cycle the station select, the 4-bit subaddress and the 5-bit function code are valid. The block answers in the next cycle with the accept flag (X), the response flag (Q) and, for reads, the count of the addressed channel. It also sends a one-cycle clear pulse and one-cycle test pulses to the converter section.

The block holds an attention (look-at-me) flip-flop and its enable mask. The flip-flop is set by the converter's end-of-conversion pulse. The crate sees the flip-flop ANDed with the mask. Empty-card suppression works from the live channel counts: when every channel reads below a programmable threshold, reads return no Q. The attention flag is also withheld at end of conversion, unless a configuration input turns off that half of the suppression. The accept flag is returned in either case.

Top module: `dataway_responder`

## Requirements
- R1: cmd_ack is 1 in the cycle after a strobe when, and only when, stn_sel=1, sub_addr is at most NCH-1 (11), and func is one of 0, 2, 8, 9, 10, 24, 25 or 26. In every other cycle cmd_ack, resp_q, rd_data, test_gate and test_charge are 0.
- R2: An accepted func 0 or func 2 returns resp_q=1 and rd_data equal to the count of channel sub_addr, unless the card is empty. Whenever resp_q is 0, rd_data is 0.
- R3: An accepted func 8 returns resp_q equal to the attention flip-flop, whatever the mask holds.
- R4: Four events clear the card: func 9 with any valid subaddress, func 2 with sub_addr=11 only, crate_clear and crate_init. Each gives a conv_clear pulse in the next cycle and clears the attention flip-flop at the same edge.
- R5: Func 10 clears the attention flip-flop without a conv_clear pulse.
- R6: attn_req equals the flip-flop ANDed with the mask. Func 26 sets the mask. Func 24 and crate_init clear it, and crate_clear leaves it unchanged. The mask resets to the parameter MASK_INIT (default 0).
- R7: A conv_done pulse sets the attention flip-flop, which then holds until a clear. A clear in the same cycle as conv_done wins.
- R8: The card is empty when every channel count is strictly below supp_thresh. A count equal to the threshold is not below it, and a threshold of 0 never gives an empty card. An empty card returns resp_q=0 on reads.
- R9: conv_done on an empty card leaves the attention flip-flop clear, unless attn_supp_off=1.
- R10: An accepted func 25 gives a one-cycle test_gate pulse in the next cycle. test_charge pulses with it only when crate_inhibit was 1 in the strobe cycle.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stn_sel | input | 1 | Station select (N) |
| sub_addr | input | 4 | Subaddress (A) |
| func | input | 5 | Function code (F) |
| strobe | input | 1 | One-cycle command strobe (S2) |
| crate_clear | input | 1 | Crate clear (C) |
| crate_init | input | 1 | Crate initialize (Z) |
| crate_inhibit | input | 1 | Crate inhibit (I) |
| conv_done | input | 1 | End-of-conversion pulse |
| chan_counts | input | NCH*CNT_W | Channel counts, channel 0 in the low bits |
| supp_thresh | input | THR_W | Empty-card threshold |
| attn_supp_off | input | 1 | 1 turns off attention suppression |
| rd_data | output | CNT_W | Read data |
| cmd_ack | output | 1 | Command accepted (X) |
| resp_q | output | 1 | Response (Q) |
| attn_req | output | 1 | Masked attention request to the crate |
| conv_clear | output | 1 | Clear pulse to the converters |
| test_gate | output | 1 | Test gate pulse |
| test_charge | output | 1 | Test charge injection pulse |

## Verification
The assertions assume single-cycle strobes and single-cycle conv_done pulses. They also assume that station select, subaddress and function are steady during the strobe cycle. The bench drives every command through one task that raises the strobe for exactly one cycle on the falling edge, with the address lines set at the same moment. Channel counts and threshold change only while no command or conversion pulse is in flight. Commands never overlap; the only deliberate overlap is the conv_done pulse placed in the same cycle as a clear.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int SA_W = 4;
  localparam int FN_W = 5;

  typedef enum logic [FN_W-1:0] {
    FN_READ      = 5'd0,
    FN_READ_CLR  = 5'd2,
    FN_TEST_ATTN = 5'd8,
    FN_CLR_MOD   = 5'd9,
    FN_CLR_ATTN  = 5'd10,
    FN_MASK_OFF  = 5'd24,
    FN_TEST      = 5'd25,
    FN_MASK_ON   = 5'd26
  } fn_e;

  typedef struct packed {
    logic valid;
    logic is_read;
    logic is_attn_test;
    logic clr_module;
    logic clr_attn;
    logic mask_on;
    logic mask_off;
    logic is_test;
  } dec_t;
endpackage

// File: rtl/dwr_decode.sv
module dwr_decode
  import dwr_pkg::*;
#(
  parameter int NCH = 12
) (
  input  logic            stn_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic [FN_W-1:0] fn_i,
  output dec_t            dec_o
);
  localparam logic [SA_W-1:0] LAST_SA = SA_W'(NCH - 1);

  logic sa_ok;
  assign sa_ok = (sa_i <= LAST_SA);

  always_comb begin
    dec_o = '0;
    case (fn_i)
      FN_READ:      dec_o.is_read      = 1'b1;
      FN_READ_CLR:  begin
                      dec_o.is_read    = 1'b1;
                      dec_o.clr_module = (sa_i == LAST_SA);
                    end
      FN_TEST_ATTN: dec_o.is_attn_test = 1'b1;
      FN_CLR_MOD:   dec_o.clr_module   = 1'b1;
      FN_CLR_ATTN:  dec_o.clr_attn     = 1'b1;
      FN_MASK_OFF:  dec_o.mask_off     = 1'b1;
      FN_TEST:      dec_o.is_test      = 1'b1;
      FN_MASK_ON:   dec_o.mask_on      = 1'b1;
      default:      dec_o              = '0;
    endcase
    dec_o.valid = stn_i & sa_ok &
                  (dec_o.is_read | dec_o.is_attn_test | dec_o.clr_module |
                   dec_o.clr_attn | dec_o.mask_on | dec_o.mask_off | dec_o.is_test |
                   (fn_i == FN_CLR_MOD));
  end
endmodule

// File: rtl/dwr_empty_det.sv
module dwr_empty_det #(
  parameter int NCH   = 12,
  parameter int CNT_W = 11,
  parameter int THR_W = 8
) (
  input  logic [NCH*CNT_W-1:0] counts_i,
  input  logic [THR_W-1:0]     thresh_i,
  output logic                 empty_o
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [NCH-1:0]   below;
  logic [CMP_W-1:0] thr_ext;
  assign thr_ext = CMP_W'(thresh_i);

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign below[g] = CMP_W'(counts_i[g*CNT_W +: CNT_W]) < thr_ext;
  end

  assign empty_o = &below;

  always_comb begin
    if (thresh_i == '0) begin
      AST_THR0_NOT_EMPTY: assert (!empty_o); // R8
    end
  end
endmodule

// File: rtl/dwr_attn.sv
module dwr_attn #(
  parameter bit MASK_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_on_i,
  input  logic mask_off_i,
  output logic flag_o,
  output logic attn_o
);
  logic flag_q, flag_d, flag_en;
  logic mask_q, mask_d, mask_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = ~clr_i;
    mask_en = mask_on_i | mask_off_i;
    mask_d  = ~mask_off_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= MASK_INIT;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign flag_o = flag_q;
  assign attn_o = flag_q & mask_q;

  AST_FLAG_RISE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i)); // R7
  AST_CLEAR_EMPTIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q); // R4
endmodule

// File: rtl/dataway_responder.sv
module dataway_responder
  import dwr_pkg::*;
#(
  parameter int NCH       = 12,
  parameter int CNT_W     = 11,
  parameter int THR_W     = 8,
  parameter bit MASK_INIT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stn_sel,
  input  logic [3:0]           sub_addr,
  input  logic [4:0]           func,
  input  logic                 strobe,
  input  logic                 crate_clear,
  input  logic                 crate_init,
  input  logic                 crate_inhibit,
  input  logic                 conv_done,
  input  logic [NCH*CNT_W-1:0] chan_counts,
  input  logic [THR_W-1:0]     supp_thresh,
  input  logic                 attn_supp_off,
  output logic [CNT_W-1:0]     rd_data,
  output logic                 cmd_ack,
  output logic                 resp_q,
  output logic                 attn_req,
  output logic                 conv_clear,
  output logic                 test_gate,
  output logic                 test_charge
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  dec_t dec;
  logic empty, flag;

  dwr_decode #(.NCH(NCH)) u_dec (
    .stn_i(stn_sel), .sa_i(sub_addr), .fn_i(func), .dec_o(dec)
  );

  dwr_empty_det #(.NCH(NCH), .CNT_W(CNT_W), .THR_W(THR_W)) u_empty (
    .counts_i(chan_counts), .thresh_i(supp_thresh), .empty_o(empty)
  );

  logic hit, clr_mod_all, clr_attn_all, set_attn, mask_on, mask_off;
  always_comb begin
    hit          = strobe & dec.valid;
    clr_mod_all  = crate_clear | crate_init | (hit & dec.clr_module);
    clr_attn_all = clr_mod_all | (hit & dec.clr_attn);
    set_attn     = conv_done & (~empty | attn_supp_off);
    mask_on      = hit & dec.mask_on;
    mask_off     = crate_init | (hit & dec.mask_off);
  end

  dwr_attn #(.MASK_INIT(MASK_INIT)) u_attn (
    .clk(clk), .rst_n(rst_s), .set_i(set_attn), .clr_i(clr_attn_all),
    .mask_on_i(mask_on), .mask_off_i(mask_off), .flag_o(flag), .attn_o(attn_req)
  );

  logic [CNT_W-1:0] chan [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign chan[g] = chan_counts[g*CNT_W +: CNT_W];
  end

  logic [CNT_W-1:0] sel_cnt;
  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sub_addr == 4'(i)) sel_cnt = chan[i];
    end
  end

  logic             ack_d, q_d, cclr_d, gate_d, charge_d, rsp_en;
  logic [CNT_W-1:0] data_d;
  logic             ack_q, q_q, cclr_q, gate_q, charge_q;
  logic [CNT_W-1:0] data_q;

  always_comb begin
    rsp_en   = hit | ack_q | cclr_q | clr_mod_all;
    ack_d    = hit;
    q_d      = hit & ((dec.is_read & ~empty) | (dec.is_attn_test & flag));
    data_d   = (hit & dec.is_read & ~empty) ? sel_cnt : '0;
    cclr_d   = clr_mod_all;
    gate_d   = hit & dec.is_test;
    charge_d = hit & dec.is_test & crate_inhibit;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ack_q    <= 1'b0;
      q_q      <= 1'b0;
      data_q   <= '0;
      cclr_q   <= 1'b0;
      gate_q   <= 1'b0;
      charge_q <= 1'b0;
    end else if (rsp_en) begin
      ack_q    <= ack_d;
      q_q      <= q_d;
      data_q   <= data_d;
      cclr_q   <= cclr_d;
      gate_q   <= gate_d;
      charge_q <= charge_d;
    end
  end

  assign cmd_ack     = ack_q;
  assign resp_q      = q_q;
  assign rd_data     = data_q;
  assign conv_clear  = cclr_q;
  assign test_gate   = gate_q;
  assign test_charge = charge_q;

  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_ack |-> $past(strobe)); // R1
  AST_Q_IMPLIES_ACK: assert property (@(posedge clk) disable iff (!rst_s)
    resp_q |-> cmd_ack); // R3
  AST_DATA_ZERO_WITHOUT_Q: assert property (@(posedge clk) disable iff (!rst_s)
    !resp_q |-> (rd_data == '0)); // R2
  AST_GATE_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_s)
    (test_gate || test_charge) |-> cmd_ack); // R10
endmodule

// File: tb/dataway_responder_test.sv
`timescale 1ns/1ps
module dataway_responder_test;
  localparam int NCH = 12;
  localparam int CNT_W = 11;
  localparam int THR_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, stn, stb, cclr, cinit, cinh, done, soff;
  logic [3:0] sa;
  logic [4:0] fn;
  logic [NCH*CNT_W-1:0] counts;
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] rd_data;
  logic ack, q, attn, cvclr, tgate, tcharge;

  dataway_responder #(.NCH(NCH), .CNT_W(CNT_W), .THR_W(THR_W)) uut (
    .clk(clk), .rst_n(rst_n), .stn_sel(stn), .sub_addr(sa), .func(fn),
    .strobe(stb), .crate_clear(cclr), .crate_init(cinit), .crate_inhibit(cinh),
    .conv_done(done), .chan_counts(counts), .supp_thresh(thr),
    .attn_supp_off(soff), .rd_data(rd_data), .cmd_ack(ack), .resp_q(q),
    .attn_req(attn), .conv_clear(cvclr), .test_gate(tgate), .test_charge(tcharge)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  // {stn, sub_addr, func, expected X, expected Q}
  localparam logic [11:0] VEC [14] = '{
    {1'b1, 4'd0,  5'd0,  1'b1, 1'b1},
    {1'b1, 4'd11, 5'd0,  1'b1, 1'b1},
    {1'b1, 4'd12, 5'd0,  1'b0, 1'b0},
    {1'b0, 4'd3,  5'd0,  1'b0, 1'b0},
    {1'b1, 4'd5,  5'd1,  1'b0, 1'b0},
    {1'b1, 4'd4,  5'd8,  1'b1, 1'b0},
    {1'b1, 4'd2,  5'd10, 1'b1, 1'b0},
    {1'b1, 4'd1,  5'd24, 1'b1, 1'b0},
    {1'b1, 4'd1,  5'd26, 1'b1, 1'b0},
    {1'b1, 4'd7,  5'd16, 1'b0, 1'b0},
    {1'b1, 4'd15, 5'd9,  1'b0, 1'b0},
    {1'b1, 4'd3,  5'd2,  1'b1, 1'b1},
    {1'b1, 4'd6,  5'd25, 1'b1, 1'b0},
    {1'b1, 4'd0,  5'd31, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic n, input logic [3:0] a, input logic [4:0] f);
    @(negedge clk);
    stn = n; sa = a; fn = f; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0; stn = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic pulse_c();
    @(negedge clk); cclr = 1'b1;
    @(negedge clk); cclr = 1'b0;
  endtask

  task automatic pulse_z();
    @(negedge clk); cinit = 1'b1;
    @(negedge clk); cinit = 1'b0;
  endtask

  function automatic logic [31:0] cnt_of(input int ch);
    return 32'(100 + 10 * ch);
  endfunction

  initial begin
    #(100000 * 5);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stn = 1'b0; stb = 1'b0; cclr = 1'b0; cinit = 1'b0;
    cinh = 1'b0; done = 1'b0; soff = 1'b0; sa = '0; fn = '0; thr = 8'd50;
    for (int i = 0; i < NCH; i++) counts[i*CNT_W +: CNT_W] = CNT_W'(cnt_of(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 ack", ack, 0);
    chk("R11 q", q, 0);
    chk("R11 data", rd_data, 0);
    chk("R11 attn", attn, 0);
    chk("R11 conv_clear", cvclr, 0);
    chk("R11 test pulses", {tgate, tcharge}, 0);

    // R1 / R2 decode table
    for (int v = 0; v < 14; v++) begin
      logic [11:0] e;
      e = VEC[v];
      cmd(e[11], e[10:7], e[6:2]);
      chk($sformatf("R1 X vec%0d", v), ack, e[1]);
      chk($sformatf("R2 Q vec%0d", v), q, e[0]);
      chk($sformatf("R2 data vec%0d", v), rd_data, e[0] ? cnt_of(int'(e[10:7])) : 0);
    end
    @(negedge clk);
    chk("R1 idle outputs", {ack, q, tgate, tcharge}, 0);

    // R7 set on conversion; R3 test
    pulse_done();
    chk("R7 attn set", attn, 1);
    cmd(1'b1, 4'd0, 5'd8);
    chk("R3 test Q set", q, 1);
    // R6 mask
    cmd(1'b1, 4'd0, 5'd24);
    chk("R6 mask off", attn, 0);
    cmd(1'b1, 4'd0, 5'd8);
    chk("R3 test Q ignores mask", q, 1);
    cmd(1'b1, 4'd0, 5'd26);
    chk("R6 mask on", attn, 1);
    // R5 clear attention only
    cmd(1'b1, 4'd0, 5'd10);
    chk("R5 attn cleared", attn, 0);
    chk("R5 no conv_clear", cvclr, 0);
    cmd(1'b1, 4'd0, 5'd8);
    chk("R5 test Q after clear", q, 0);
    // R4 read-and-clear on last subaddress
    pulse_done();
    cmd(1'b1, 4'd11, 5'd2);
    chk("R4 f2 q", q, 1);
    chk("R4 f2 data", rd_data, cnt_of(11));
    chk("R4 f2 conv_clear", cvclr, 1);
    chk("R4 f2 attn", attn, 0);
    // R4 module clear
    pulse_done();
    cmd(1'b1, 4'd5, 5'd9);
    chk("R4 f9 conv_clear", cvclr, 1);
    chk("R4 f9 attn", attn, 0);
    // R7 clear beats set
    @(negedge clk);
    done = 1'b1; stn = 1'b1; sa = 4'd0; fn = 5'd10; stb = 1'b1;
    @(negedge clk);
    done = 1'b0; stb = 1'b0; stn = 1'b0;
    chk("R7 clear priority", attn, 0);
    // R4 crate clear, R6 mask survives it
    pulse_done();
    pulse_c();
    chk("R4 C attn", attn, 0);
    chk("R4 C conv_clear", cvclr, 1);
    pulse_done();
    chk("R6 mask kept after C", attn, 1);
    // R4 / R6 crate initialize
    pulse_z();
    chk("R4 Z attn", attn, 0);
    chk("R4 Z conv_clear", cvclr, 1);
    pulse_done();
    chk("R6 mask cleared by Z", attn, 0);
    cmd(1'b1, 4'd0, 5'd8);
    chk("R3 flag set under cleared mask", q, 1);
    cmd(1'b1, 4'd0, 5'd10);
    cmd(1'b1, 4'd0, 5'd26);
    // R8 / R9 empty card
    thr = 8'd250;
    cmd(1'b1, 4'd0, 5'd0);
    chk("R8 empty X", ack, 1);
    chk("R8 empty Q", q, 0);
    chk("R8 empty data", rd_data, 0);
    pulse_done();
    chk("R9 suppressed attn", attn, 0);
    cmd(1'b1, 4'd0, 5'd8);
    chk("R9 suppressed flag", q, 0);
    soff = 1'b1;
    pulse_done();
    chk("R9 suppression off", attn, 1);
    soff = 1'b0;
    cmd(1'b1, 4'd0, 5'd10);
    // R8 threshold boundary
    thr = 8'd210;
    cmd(1'b1, 4'd11, 5'd0);
    chk("R8 equal not below", q, 1);
    thr = 8'd211;
    cmd(1'b1, 4'd11, 5'd0);
    chk("R8 all below", q, 0);
    thr = 8'd0;
    cmd(1'b1, 4'd4, 5'd0);
    chk("R8 zero threshold", q, 1);
    thr = 8'd50;
    // R10 test pulses
    cinh = 1'b0;
    cmd(1'b1, 4'd0, 5'd25);
    chk("R10 gate", tgate, 1);
    chk("R10 no charge", tcharge, 0);
    cinh = 1'b1;
    cmd(1'b1, 4'd3, 5'd25);
    chk("R10 gate with inhibit", tgate, 1);
    chk("R10 charge with inhibit", tcharge, 1);
    cmd(1'b1, 4'd12, 5'd25);
    chk("R10 bad subaddress no gate", tgate, 0);
    cinh = 1'b0;
    @(negedge clk);
    chk("R10 gate one cycle", tgate, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule